// File: doc/BRIEF.md
# Per-Source Configurable Interrupt Controller

This block merges up to 32 asynchronous event inputs into a single interrupt request line. Every input gets its own sensitivity choice (level or edge) and its own active sense (high or low). A detected event latches into a sticky status bit. Software clears that bit by writing a one to it. An enable mask decides which latched bits may drive the request line.

Only some bit positions carry a source, and each position is fixed:

| Bits | Source |
| --- | --- |
| 0 | frame-valid start |
| 1 | frame-valid end |
| 8 to 11 | transmit FIFO empty, almost-empty, almost-full, full |
| 12 to 15 | receive FIFO empty, almost-empty, almost-full, full |
| 17 to 22 | command-line channels 1 to 6 (channel c on bit 16+c) |

Every other position, including the slots for command channel 0 (bit 16) and channel 7 (bit 23), is unimplemented.

A small word-wide register port gives access to four registers: enable, status, edge select and low-polarity select. Reads of the port are combinational.

Top module: `irq_ctrl`

## Requirements
- R1: After rst_ni is released, all four registers read zero and irq_o is low.
- R2: Each input passes two synchronizer flops. A level that is present before rising edge k sets its status bit at edge k+2. The bit is still clear when sampled after edge k+1.
- R3: A source in level mode (edge bit 0) sets its status bit for as long as the input is at its active level. A write-one-to-clear has no lasting effect while that level persists.
- R4: A source in edge mode (edge bit 1) sets its status bit only on a transition into its active level. Holding that level after a clear leaves the bit clear.
- R5: Polarity bit 0 selects an active-high source (rising edge in edge mode). Polarity bit 1 selects an active-low source (falling edge in edge mode).
- R6: Writing the status register clears every bit written as 1 and leaves bits written as 0 unchanged.
- R7: irq_o is high exactly when some status bit and the matching enable bit are both 1.
- R8: Writing zero to the enable register forces irq_o low on the next cycle. Status bits are retained.
- R9: Implemented sources are bits 0, 1, 8 to 15 and 17 to 22 (mask 0x007EFF03). Every other bit reads zero in all four registers and never sets status, never requests an interrupt, and ignores writes.
- R10: Register addresses are: 0 enable, 1 status (write-one-to-clear), 2 edge select, 3 low-polarity select. A write occurs on a rising edge with reg_wr_i high. reg_rdata_o shows the addressed register in the same cycle.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Raw event inputs, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions check four things on every cycle:
- Every bit raised by the detector appears in status on the next cycle.
- Status bits fall only after a write-one-to-clear that is not overridden by a simultaneous set.
- Unimplemented bits never show up in the readback.
- A zero written to the enable register drops the request line.

Some behaviours depend on the synchronizer stages and on what the input does over time, so only the bench scenarios can show them. These are the exact latency through the synchronizer, level persistence against clearing, a single set per transition in edge mode, inverted sense for active-low sources, and the masking of the command-line slots for channels 0 and 7.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned NUM_SRC = 32;
  localparam int unsigned REG_AW  = 2;

  localparam logic [REG_AW-1:0] ADDR_ENABLE  = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_STATUS  = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_EDGE    = 2'd2;
  localparam logic [REG_AW-1:0] ADDR_POL_LOW = 2'd3;

  localparam int unsigned SRC_FRAME_START = 0;
  localparam int unsigned SRC_FRAME_END   = 1;
  localparam int unsigned SRC_TX_FIRST    = 8;   // empty, almost-empty, almost-full, full
  localparam int unsigned SRC_RX_FIRST    = 12;  // same order as transmit group
  localparam int unsigned FIFO_FLAGS      = 4;
  localparam int unsigned CMD_BASE        = 16;  // channel c sits at CMD_BASE + c
  localparam int unsigned CMD_FIRST       = 1;
  localparam int unsigned CMD_LAST        = 6;

  function automatic logic [NUM_SRC-1:0] build_valid();
    logic [NUM_SRC-1:0] m;
    m = '0;
    m[SRC_FRAME_START] = 1'b1;
    m[SRC_FRAME_END]   = 1'b1;
    for (int f = 0; f < FIFO_FLAGS; f++) begin
      m[SRC_TX_FIRST + f] = 1'b1;
      m[SRC_RX_FIRST + f] = 1'b1;
    end
    for (int c = CMD_FIRST; c <= CMD_LAST; c++) m[CMD_BASE + c] = 1'b1;
    return m;
  endfunction

  localparam logic [NUM_SRC-1:0] VALID_MASK = build_valid();
endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_src_detect.sv
module irq_src_detect #(
  parameter int unsigned            WIDTH = 32,
  parameter logic [WIDTH-1:0]       VALID = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sync_i,
  input  logic [WIDTH-1:0] edge_mode_i,
  input  logic [WIDTH-1:0] pol_low_i,
  output logic [WIDTH-1:0] set_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_src
    if (VALID[i]) begin : g_impl
      logic act, prev_q;
      assign act = sync_i[i] ^ pol_low_i[i];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= act;
      end
      assign set_o[i] = edge_mode_i[i] ? (act & ~prev_q) : act;
    end else begin : g_none
      assign set_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned      WIDTH = NUM_SRC,
  parameter logic [WIDTH-1:0] VALID = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic [WIDTH-1:0]  set_i,
  output logic [WIDTH-1:0]  enable_o,
  output logic [WIDTH-1:0]  status_o,
  output logic [WIDTH-1:0]  edge_mode_o,
  output logic [WIDTH-1:0]  pol_low_o
);
  logic [WIDTH-1:0] enable_q, status_q, edge_q, pol_q, w1c;

  assign w1c = (wr_i && addr_i == ADDR_STATUS) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_q <= '0;
      status_q <= '0;
      edge_q   <= '0;
      pol_q    <= '0;
    end else begin
      // a set in the same cycle as a clear wins
      status_q <= ((status_q & ~w1c) | set_i) & VALID;
      if (wr_i && addr_i == ADDR_ENABLE)  enable_q <= wdata_i & VALID;
      if (wr_i && addr_i == ADDR_EDGE)    edge_q   <= wdata_i & VALID;
      if (wr_i && addr_i == ADDR_POL_LOW) pol_q    <= wdata_i & VALID;
    end
  end

  assign enable_o    = enable_q;
  assign status_o    = status_q;
  assign edge_mode_o = edge_q;
  assign pol_low_o   = pol_q;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               reg_wr_i,
  input  logic [REG_AW-1:0]  reg_addr_i,
  input  logic [NUM_SRC-1:0] reg_wdata_i,
  output logic [NUM_SRC-1:0] reg_rdata_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] sync_w, set_w, enable_w, status_w, edge_w, pol_w;

  irq_src_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (src_i),
    .q_o   (sync_w)
  );

  irq_src_detect #(.WIDTH(NUM_SRC), .VALID(VALID_MASK)) u_detect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_i     (sync_w),
    .edge_mode_i(edge_w),
    .pol_low_i  (pol_w),
    .set_o      (set_w)
  );

  irq_regs #(.WIDTH(NUM_SRC), .VALID(VALID_MASK)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .set_i      (set_w),
    .enable_o   (enable_w),
    .status_o   (status_w),
    .edge_mode_o(edge_w),
    .pol_low_o  (pol_w)
  );

  always_comb begin
    unique case (reg_addr_i)
      ADDR_ENABLE: reg_rdata_o = enable_w;
      ADDR_STATUS: reg_rdata_o = status_w;
      ADDR_EDGE:   reg_rdata_o = edge_w;
      default:     reg_rdata_o = pol_w;
    endcase
  end

  assign irq_o = |(status_w & enable_w);
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_ctrl_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               reg_wr_i,
  input logic [REG_AW-1:0]  reg_addr_i,
  input logic [NUM_SRC-1:0] reg_wdata_i,
  input logic [NUM_SRC-1:0] reg_rdata_o,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] set_w,
  input logic [NUM_SRC-1:0] status_w
);
  // R3 R4
  set_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> ((status_w & $past(set_w & VALID_MASK)) == $past(set_w & VALID_MASK)));

  // R6
  w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == ADDR_STATUS)
      |=> ((status_w & $past(reg_wdata_i & ~set_w)) == '0));

  // R6
  status_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_i && reg_addr_i == ADDR_STATUS)
      |=> ((status_w & $past(status_w)) == $past(status_w)));

  // R8
  enable_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == ADDR_ENABLE && reg_wdata_i == '0) |=> !irq_o);

  // R9
  unused_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o & ~VALID_MASK) == '0);
endmodule

bind irq_ctrl irq_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_wr_i   (reg_wr_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o),
  .irq_o      (irq_o),
  .set_w      (set_w),
  .status_w   (status_w)
);

// File: tb/irq_ctrl_bench.sv
`timescale 1ns/1ps
module irq_ctrl_bench;
  localparam logic [31:0] VALID = 32'h007E_FF03;
  localparam logic [1:0] A_EN = 2'd0, A_ST = 2'd1, A_EDGE = 2'd2, A_POL = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  irq_ctrl u_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 4; a++) begin
      rd_reg(a[1:0], d);
      check("R1 reset reg / R10 addr", d, 32'h0);
    end
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_latency_enable();
    logic [31:0] d;
    @(negedge clk);
    src[0] = 1'b1;
    idle(2);
    rd_reg(A_ST, d);
    check("R2 status not yet set after two edges", d, 32'h0);
    idle(1);
    rd_reg(A_ST, d);
    check("R2 status set on third edge", d, 32'h1);
    check("R7 irq low while masked", {31'b0, irq}, 32'h0);
    src[0] = 1'b0;
    wr_reg(A_EN, 32'h1);
    #0.5;
    check("R7 irq high when enabled", {31'b0, irq}, 32'h1);
    wr_reg(A_EN, 32'h0);
    #0.5;
    check("R8 irq low after enable zero", {31'b0, irq}, 32'h0);
    rd_reg(A_ST, d);
    check("R8 status kept after disable", d, 32'h1);
    idle(4);
    wr_reg(A_ST, 32'h2);
    rd_reg(A_ST, d);
    check("R6 zero-written bit kept", d, 32'h1);
    wr_reg(A_ST, 32'h1);
    rd_reg(A_ST, d);
    check("R6 one-written bit cleared", d, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    @(negedge clk);
    src[9] = 1'b1;
    idle(4);
    wr_reg(A_ST, 32'h200);
    idle(1);
    rd_reg(A_ST, d);
    check("R3 level bit persists through clear", d, 32'h200);
    src[9] = 1'b0;
    idle(4);
    wr_reg(A_ST, 32'h200);
    rd_reg(A_ST, d);
    check("R3 level bit clears once inactive", d, 32'h0);
    wr_reg(A_POL, 32'h2000);
    idle(4);
    rd_reg(A_ST, d);
    check("R5 active-low level sets on low input", d, 32'h2000);
    src[13] = 1'b1;
    idle(4);
    wr_reg(A_ST, 32'h2000);
    idle(2);
    rd_reg(A_ST, d);
    check("R5 active-low level clear on high input", d, 32'h0);
    wr_reg(A_POL, 32'h0);
    src[13] = 1'b0;
    idle(4);
    wr_reg(A_ST, '1);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr_reg(A_EDGE, 32'h2);
    @(negedge clk);
    src[1] = 1'b1;
    idle(4);
    rd_reg(A_ST, d);
    check("R4 rising edge sets", d, 32'h2);
    wr_reg(A_ST, 32'h2);
    idle(4);
    rd_reg(A_ST, d);
    check("R4 held level does not reset bit", d, 32'h0);
    src[1] = 1'b0;
    idle(4);
    rd_reg(A_ST, d);
    check("R4 falling edge ignored when active-high", d, 32'h0);
    src[1] = 1'b1;
    idle(4);
    rd_reg(A_ST, d);
    check("R4 second rising edge sets", d, 32'h2);
    src[1] = 1'b0;
    wr_reg(A_EDGE, 32'h0002_0000);
    wr_reg(A_POL, 32'h0002_0000);
    src[17] = 1'b1;
    idle(4);
    wr_reg(A_ST, '1);
    idle(2);
    rd_reg(A_ST, d);
    check("R5 idle-high active-low edge source clear", d, 32'h0);
    src[17] = 1'b0;
    idle(4);
    rd_reg(A_ST, d);
    check("R5 falling edge sets active-low", d, 32'h0002_0000);
    wr_reg(A_EDGE, 32'h0);
    wr_reg(A_POL, 32'h0);
    wr_reg(A_ST, '1);
  endtask

  task automatic t_valid();
    logic [31:0] d;
    wr_reg(A_EN, '1);
    wr_reg(A_EDGE, '1);
    wr_reg(A_POL, '1);
    rd_reg(A_EN, d);   check("R9 enable readback mask", d, VALID);
    rd_reg(A_EDGE, d); check("R9 edge readback mask", d, VALID);
    rd_reg(A_POL, d);  check("R9 polarity readback mask", d, VALID);
    wr_reg(A_EDGE, '0);
    wr_reg(A_POL, '0);
    src = '1;
    idle(4);
    rd_reg(A_ST, d);
    check("R9 only implemented sources latch (ch0/ch7 rejected)", d, VALID);
    wr_reg(A_EN, ~VALID);
    rd_reg(A_EN, d);
    check("R9 unused enable bits ignored", d, 32'h0);
    check("R9 no request from unused bits", {31'b0, irq}, 32'h0);
    src = '0;
    idle(4);
    wr_reg(A_ST, '1);
    rd_reg(A_ST, d);
    check("R6 full clear", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency_enable();
    t_level();
    t_edge();
    t_valid();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule